// File: doc/BRIEF.md
# Edge-Detect Interrupt Controller

The block watches a bank of already-synchronized digital input lines, 24 by default. It can arm each line for rising edges, for falling edges, or for both. It compares every input sample with the sample taken one clock earlier. When a line changes in an armed direction, the block records one shared edge event. If another armed edge arrives while that event is still pending, the block also records an overflow. Software clears the two flags independently by writing a command byte.

All of the block's state is reached through a byte-wide register port.

- **Writes** take effect at the clock edge when `reg_wr` is high.
- **Reads** are combinational from `reg_addr`.

The interrupt request is built from three things: a global enable, one enable per cause, and the two latched flags. The status byte reports the request itself, so software sharing an interrupt line can poll it.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every arm mask byte, the control byte and the status byte read 0x00, and `irq` is low.
- R2: The rising arm mask for lines 8k..8k+7 is a read/write byte at address 0x18+k. The falling arm mask for the same lines is at 0x20+k. Bit j of each byte belongs to line 8k+j, and the value read back equals the value last written.
- R3: The control byte at 0x15 is read/write. Its bits are: bit0 edge interrupt enable, bit1 overflow interrupt enable, bit2 global interrupt enable, bit3 rising detection enable, bit4 falling detection enable. Bits 7..5 always read 0.
- R4: A line going from 0 to 1 between two consecutive clock samples counts as an armed edge when its rising arm bit and control bit3 are both 1. The edge sets the edge-pending flag, which is status bit0, in the cycle after the sample that shows the change.
- R5: A line going from 1 to 0 counts as an armed edge when its falling arm bit and control bit4 are both 1. It sets status bit0 with the same timing as R4.
- R6: A transition on a line whose arm bit for that direction is 0, or whose direction is disabled in control, leaves the status unchanged.
- R7: An armed edge that arrives while status bit0 is already set sets the overflow flag, status bit1. The overflow flag then stays set until it is cleared, even after the edge flag is cleared.
- R8: Writing the clear command at 0x07 handles the flags as follows:
  - with bit3 set, it clears status bit0;
  - with bit2 set, it clears status bit1;
  - with both bits set, it clears both flags in one write;
  - its other bits have no effect.
- R9: When a clear of the edge flag and a new armed edge occur in the same cycle, the edge flag stays set. No overflow is recorded for that edge.
- R10: `irq` equals control bit2 AND ((status bit0 AND control bit0) OR (status bit1 AND control bit1)). Status bit2 reads the same value, so it is 0 whenever no request is raised.
- R11: An address that is not mapped reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 24 | Synchronized input lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are due in the same cycle as the address, after a short settle delay. A register write becomes visible from the next cycle.

An input change driven before a clock edge is seen at that edge. The change reaches status and `irq` right after that edge, one cycle after the stimulus.

The bench drives every input at the falling clock edge and lets it settle. It then compares `reg_rdata` and `irq` against its reference model. After that it advances the model across the following rising edge. This keeps every comparison exactly one register stage behind the stimulus, with no ordering races.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W     = 6;
  localparam int CLR_ADDR   = 'h07;
  localparam int STAT_ADDR  = 'h14;
  localparam int CTRL_ADDR  = 'h15;
  localparam int RISE_BASE  = 'h18;
  localparam int FALL_BASE  = 'h20;

  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;

  // control byte, bit 4 down to bit 0
  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic glob_ie;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

  function automatic logic irq_of(input ctrl_t c, input logic pend, input logic ovf);
    return c.glob_ie & ((pend & c.edge_ie) | (ovf & c.ovf_ie));
  endfunction
endpackage

// File: rtl/eic_regs.sv
module eic_regs #(
  parameter int N_LINES = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [eic_pkg::ADDR_W-1:0] reg_addr,
  input  logic [7:0]                 reg_wdata,
  input  logic                       st_pend,
  input  logic                       st_ovf,
  input  logic                       st_irq,
  output logic [7:0]                 reg_rdata,
  output logic [N_LINES-1:0]         arm_rise,
  output logic [N_LINES-1:0]         arm_fall,
  output eic_pkg::ctrl_t             ctrl_q,
  output logic                       clr_edge,
  output logic                       clr_ovf
);
  import eic_pkg::*;

  localparam int N_BYTES = N_LINES / 8;

  logic [ADDR_W-1:0] a_ctrl, a_stat, a_clr;
  assign a_ctrl = ADDR_W'(CTRL_ADDR);
  assign a_stat = ADDR_W'(STAT_ADDR);
  assign a_clr  = ADDR_W'(CLR_ADDR);

  // one byte register per lane and polarity
  for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
    logic hit_r, hit_f;
    assign hit_r = reg_wr && (reg_addr == ADDR_W'(RISE_BASE + k));
    assign hit_f = reg_wr && (reg_addr == ADDR_W'(FALL_BASE + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_rise[8*k +: 8] <= '0;
        arm_fall[8*k +: 8] <= '0;
      end else begin
        if (hit_r) arm_rise[8*k +: 8] <= reg_wdata;
        if (hit_f) arm_fall[8*k +: 8] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (reg_wr && reg_addr == a_ctrl) ctrl_q <= ctrl_t'(reg_wdata[4:0]);
  end

  assign clr_edge = reg_wr && (reg_addr == a_clr) && reg_wdata[CLR_EDGE_BIT];
  assign clr_ovf  = reg_wr && (reg_addr == a_clr) && reg_wdata[CLR_OVF_BIT];

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == a_ctrl) reg_rdata = {3'b000, ctrl_q};
    if (reg_addr == a_stat) reg_rdata = {5'b00000, st_irq, st_ovf, st_pend};
    for (int k = 0; k < N_BYTES; k++) begin
      if (reg_addr == ADDR_W'(RISE_BASE + k)) reg_rdata = arm_rise[8*k +: 8];
      if (reg_addr == ADDR_W'(FALL_BASE + k)) reg_rdata = arm_fall[8*k +: 8];
    end
  end
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
  parameter int N_LINES = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] din,
  input  logic [N_LINES-1:0] arm_rise,
  input  logic [N_LINES-1:0] arm_fall,
  input  logic               rise_en,
  input  logic               fall_en,
  output logic               edge_hit
);
  localparam int N_BYTES = N_LINES / 8;

  function automatic logic [7:0] lane_hits(
    input logic [7:0] cur, input logic [7:0] prev,
    input logic [7:0] ar,  input logic [7:0] af,
    input logic ren, input logic fen);
    return (cur & ~prev & ar & {8{ren}}) | (~cur & prev & af & {8{fen}});
  endfunction

  logic [N_LINES-1:0] prev_q;
  logic [N_BYTES-1:0] lane_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
    assign lane_any[k] = |lane_hits(din[8*k +: 8], prev_q[8*k +: 8],
                                    arm_rise[8*k +: 8], arm_fall[8*k +: 8],
                                    rise_en, fall_en);
  end

  assign edge_hit = |lane_any;
endmodule

// File: rtl/eic_event.sv
module eic_event (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           edge_hit,
  input  logic           clr_edge,
  input  logic           clr_ovf,
  input  eic_pkg::ctrl_t ctrl_q,
  output logic           pend_q,
  output logic           ovf_q,
  output logic           irq
);
  logic ovf_set;
  // a new edge counts as lost only if the earlier one is not being cleared
  assign ovf_set = edge_hit && pend_q && !clr_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= edge_hit | (pend_q & ~clr_edge);
      ovf_q  <= ovf_set  | (ovf_q  & ~clr_ovf);
    end
  end

  assign irq = eic_pkg::irq_of(ctrl_q, pend_q, ovf_q);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int N_LINES = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         din,
  input  logic                       reg_wr,
  input  logic [eic_pkg::ADDR_W-1:0] reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  output logic                       irq
);
  logic [N_LINES-1:0] arm_rise, arm_fall;
  eic_pkg::ctrl_t     ctrl_q;
  logic               clr_edge, clr_ovf, edge_hit, pend_q, ovf_q;

  eic_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .st_pend(pend_q), .st_ovf(ovf_q), .st_irq(irq),
    .reg_rdata(reg_rdata), .arm_rise(arm_rise), .arm_fall(arm_fall),
    .ctrl_q(ctrl_q), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );

  eic_edge_det #(.N_LINES(N_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .din(din), .arm_rise(arm_rise),
    .arm_fall(arm_fall), .rise_en(ctrl_q.rise_en), .fall_en(ctrl_q.fall_en),
    .edge_hit(edge_hit)
  );

  eic_event u_evt (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .clr_edge(clr_edge),
    .clr_ovf(clr_ovf), .ctrl_q(ctrl_q), .pend_q(pend_q), .ovf_q(ovf_q),
    .irq(irq)
  );
endmodule

// File: rtl/eic_chk.sv
module eic_chk (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input eic_pkg::ctrl_t ctrl_q,
  input logic           edge_hit,
  input logic           pend_q,
  input logic           ovf_q,
  input logic           clr_edge,
  input logic           clr_ovf
);
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.glob_ie |-> !irq); // R10
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pend_q); // R9
  AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !edge_hit) |=> !pend_q); // R8
  AST_OVF_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(pend_q)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q); // R7
  AST_NO_SPONTANEOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !edge_hit) |=> !pend_q); // R6
endmodule

bind edge_irq_ctrl eic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ctrl_q(ctrl_q), .edge_hit(edge_hit),
  .pend_q(pend_q), .ovf_q(ovf_q), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
  localparam int NL = 24;
  localparam logic [5:0] A_CLR = 6'h07, A_STAT = 6'h14, A_CTRL = 6'h15,
                         A_RISE = 6'h18, A_FALL = 6'h20;

  logic clk = 0, rst_n = 0;
  logic [NL-1:0] din = '0;
  logic reg_wr = 0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .din(din), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // behavioural reference state
  int m_rise[3], m_fall[3];
  int m_ctrl, m_pend, m_ovf;
  bit m_prev[NL];

  function automatic int m_irq();
    int g = (m_ctrl >> 2) & 1;
    int a = (m_pend != 0 && (m_ctrl & 1) != 0) || (m_ovf != 0 && (m_ctrl & 2) != 0);
    return (g != 0 && a != 0) ? 1 : 0;
  endfunction

  function automatic int m_read(input logic [5:0] a);
    if (a == A_CTRL) return m_ctrl;
    if (a == A_STAT) return m_pend + 2 * m_ovf + 4 * m_irq();
    for (int k = 0; k < 3; k++) begin
      if (a == A_RISE + 6'(k)) return m_rise[k];
      if (a == A_FALL + 6'(k)) return m_fall[k];
    end
    return 0;
  endfunction

  task automatic m_step(input logic [NL-1:0] d, input logic w,
                        input logic [5:0] a, input logic [7:0] wd);
    bit hit = 0;
    bit ce, co;
    for (int i = 0; i < NL; i++) begin
      bit up = d[i] && !m_prev[i];
      bit dn = !d[i] && m_prev[i];
      if (up && ((m_rise[i/8] >> (i%8)) & 1) == 1 && (m_ctrl & 8) != 0) hit = 1;
      if (dn && ((m_fall[i/8] >> (i%8)) & 1) == 1 && (m_ctrl & 16) != 0) hit = 1;
      m_prev[i] = d[i];
    end
    ce = w && a == A_CLR && wd[3];
    co = w && a == A_CLR && wd[2];
    if (hit && m_pend != 0 && !ce) m_ovf = 1;
    else if (co) m_ovf = 0;
    if (hit) m_pend = 1;
    else if (ce) m_pend = 0;
    if (w) begin
      if (a == A_CTRL) m_ctrl = wd & 8'h1F;
      for (int k = 0; k < 3; k++) begin
        if (a == A_RISE + 6'(k)) m_rise[k] = wd;
        if (a == A_FALL + 6'(k)) m_fall[k] = wd;
      end
    end
  endtask

  // one cycle: drive, compare against model (and optional literal), advance
  task automatic cyc(input logic [NL-1:0] d, input logic w, input logic [5:0] a,
                     input logic [7:0] wd, input string tag, input int exp = -1);
    @(negedge clk);
    din = d; reg_wr = w; reg_addr = a; reg_wdata = wd;
    #1;
    checks++;
    if (int'(reg_rdata) != m_read(a)) begin
      fails++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, reg_rdata, m_read(a));
    end
    checks++;
    if (int'(irq) != m_irq()) begin
      fails++;
      $display("FAIL %s irq actual=%0d expected=%0d", tag, irq, m_irq());
    end
    if (exp >= 0) begin
      checks++;
      if (int'(reg_rdata) != exp) begin
        fails++;
        $display("FAIL %s literal addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
      end
    end
    @(posedge clk);
    m_step(d, w, a, wd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_ctrl = 0; m_pend = 0; m_ovf = 0;
    for (int k = 0; k < 3; k++) begin m_rise[k] = 0; m_fall[k] = 0; end
    for (int i = 0; i < NL; i++) m_prev[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    cyc(0, 0, A_CTRL, 0, "R1", 0);
    cyc(0, 0, A_STAT, 0, "R1", 0);
    cyc(0, 0, A_RISE, 0, "R1", 0);
    cyc(0, 0, A_FALL + 2, 0, "R1", 0);

    // R2 arm masks: line5 rising, line17 falling, lines16/23 rising
    cyc(0, 1, A_RISE, 8'h20, "R2");
    cyc(0, 1, A_FALL + 2, 8'h02, "R2");
    cyc(0, 1, A_RISE + 2, 8'h81, "R2");
    cyc(0, 0, A_RISE, 0, "R2", 8'h20);
    cyc(0, 0, A_FALL + 2, 0, "R2", 8'h02);
    cyc(0, 0, A_RISE + 2, 0, "R2", 8'h81);

    // R3 control byte, upper bits read zero
    cyc(0, 1, A_CTRL, 8'hFF, "R3");
    cyc(0, 0, A_CTRL, 0, "R3", 8'h1F);
    cyc(0, 1, A_CTRL, 8'h0D, "R3");
    cyc(0, 0, A_CTRL, 0, "R3", 8'h0D);

    // R4 rising edge on line 5, R10 irq raised
    cyc(24'h000020, 0, A_STAT, 0, "R4");
    cyc(24'h000020, 0, A_STAT, 0, "R4_R10", 8'h05);
    // R8 clear edge
    cyc(24'h000020, 1, A_CLR, 8'h08, "R8");
    cyc(24'h000020, 0, A_STAT, 0, "R8", 8'h00);

    // R6 line17 rise unarmed, fall with fall detection off
    cyc(24'h020020, 0, A_STAT, 0, "R6");
    cyc(24'h020020, 0, A_STAT, 0, "R6", 8'h00);
    cyc(24'h000020, 0, A_STAT, 0, "R6");
    cyc(24'h000020, 0, A_STAT, 0, "R6", 8'h00);

    // R5 falling edge on line 17 with fall detection on
    cyc(24'h000020, 1, A_CTRL, 8'h15, "R5");
    cyc(24'h020020, 0, A_STAT, 0, "R5");
    cyc(24'h000020, 0, A_STAT, 0, "R5");
    cyc(24'h000020, 0, A_STAT, 0, "R5", 8'h05);

    // R7 overflow: second edge while pending
    cyc(24'h000020, 1, A_CTRL, 8'h1F, "R7");
    cyc(24'h000000, 0, A_STAT, 0, "R7");
    cyc(24'h000020, 0, A_STAT, 0, "R7");
    cyc(24'h000020, 0, A_STAT, 0, "R7", 8'h07);
    cyc(24'h000020, 1, A_CLR, 8'h08, "R7");
    cyc(24'h000020, 0, A_STAT, 0, "R7_sticky", 8'h06);
    cyc(24'h000020, 1, A_CLR, 8'h0C, "R8");
    cyc(24'h000020, 0, A_STAT, 0, "R8_both", 8'h00);

    // R8 other clear bits ignored
    cyc(24'h000000, 0, A_STAT, 0, "R8");
    cyc(24'h000020, 0, A_STAT, 0, "R8");
    cyc(24'h000020, 1, A_CLR, 8'hF3, "R8");
    cyc(24'h000020, 0, A_STAT, 0, "R8_other", 8'h05);

    // R9 clear and new edge in the same cycle
    cyc(24'h000000, 0, A_STAT, 0, "R9");
    cyc(24'h000020, 1, A_CLR, 8'h08, "R9");
    cyc(24'h000020, 0, A_STAT, 0, "R9", 8'h05);

    // R10 gating
    cyc(24'h000020, 1, A_CTRL, 8'h1B, "R10");
    cyc(24'h000020, 0, A_STAT, 0, "R10_noglob", 8'h01);
    cyc(24'h000020, 1, A_CTRL, 8'h1E, "R10");
    cyc(24'h000020, 0, A_STAT, 0, "R10_noedgeie", 8'h01);
    cyc(24'h000020, 1, A_CTRL, 8'h1F, "R10");
    cyc(24'h000020, 0, A_STAT, 0, "R10_on", 8'h05);

    // R11 unmapped address
    cyc(24'h000020, 0, 6'h3F, 0, "R11", 8'h00);
    cyc(24'h000020, 0, 6'h10, 0, "R11", 8'h00);

    finish_run();
  end
endmodule